// File: doc/BRIEF.md
# Load/Store Address and Memory Pipeline

This block is the memory side of an out-of-order core that issues memory operations from reservation-style buffers. It holds up to three loads and two stores at a time. Each entry carries a base operand and a signed offset, and a store also carries its data. Any operand may still be pending, given as a producer tag instead of a value. Pending operands are picked up by watching two result buses: the bus from the other execution units, and this block's own load-result bus.

All entries share one address adder and one single-port data memory, and both are granted oldest-first. The sequence for a load is: one cycle in the adder, one cycle reading memory, then one cycle presenting its tagged result. A store may form its address before its data is known. It writes memory in the cycle after its data is captured, and it never produces a result. A load is kept away from memory while any older store has an unknown address or a matching address that has not yet been written. An operation marked as issued behind an unresolved branch does not start address generation until the branch is reported resolved.

Top module: `lsu_mem_pipe`

## Requirements
- R1: After reset, ldResValid, memEn, memWe, ldFull and stFull are all 0.
- R2: The effective address is the base value plus the offset sign-extended to DATA_W bits, computed in the cycle after the base value is held (offset 6'h3E means -2).
- R3: A load whose base is ready at issue in cycle k uses the adder in k+1, reads memory in k+2 (memEn=1, memWe=0, memAddr = its address), and presents ldResValid with its destination tag and the data read in k+3 for exactly one cycle.
- R4: At most one address is formed per cycle. When several entries are ready, the oldest issued goes first and the others wait.
- R5: A pending base or store-data operand is captured when its tag appears on the external bus (cdbValid) or on the block's own result bus (ldResValid). It is usable from the next cycle.
- R6: A store may form its address while its data is still pending. It writes memory (memEn=1, memWe=1, memAddr, memWdata) in the cycle after its data is captured. Stores write in issue order.
- R7: A store never asserts ldResValid.
- R8: A load does not read memory while an older store is held with an unknown address, or with the same address and no write performed yet.
- R9: Only one memory access happens per cycle. When a load read and a store write are both ready, the older operation goes first.
- R10: An entry issued with issueAfterBranch=1 forms no address until branchResolved has been 1 for a cycle. It may use the adder from the cycle after that.
- R11: ldFull and stFull are 1 when all three load entries or both store entries are held. A load entry is released at the end of its result cycle and a store entry at the end of its write cycle, so the flag drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | New memory operation this cycle |
| issueIsStore | input | 1 | 1 = store, 0 = load |
| issueAfterBranch | input | 1 | Operation lies behind an unresolved branch |
| issueBaseRdy | input | 1 | Base value is present |
| issueBaseTag | input | TAG_W | Producer tag of a pending base |
| issueBaseVal | input | DATA_W | Base value |
| issueOffset | input | OFF_W | Signed offset |
| issueDataRdy | input | 1 | Store data is present |
| issueDataTag | input | TAG_W | Producer tag of pending store data |
| issueDataVal | input | DATA_W | Store data value |
| issueDestTag | input | TAG_W | Tag a load broadcasts with |
| branchResolved | input | 1 | Pending branch condition has been computed |
| cdbValid | input | 1 | External result bus valid |
| cdbTag | input | TAG_W | External result bus tag |
| cdbData | input | DATA_W | External result bus value |
| ldFull | output | 1 | All load entries held |
| stFull | output | 1 | All store entries held |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | DATA_W | Memory address |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, same cycle as memAddr |
| ldResValid | output | 1 | Load result on the bus |
| ldResTag | output | TAG_W | Destination tag of the result |
| ldResData | output | DATA_W | Loaded value |

## Verification
Every result is due a fixed number of cycles after the event that unblocks it. For a load, memory is read two cycles after issue or after its base appears on a bus, and the result follows one cycle later. A store writes one cycle after its data is captured. A gated entry reads memory two cycles after branchResolved. Each test task counts these cycles from the cycle in which it drives the stimulus. It samples on the falling edge of exactly that cycle, and it also checks the cycle before, where the output must still be idle. This way, both an early and a late result are caught.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int ENT_IDX_W = 3;

  typedef struct packed {
    logic                 alloc;
    logic [ENT_IDX_W-1:0] allocIdx;
    logic                 agen;
    logic [ENT_IDX_W-1:0] agenIdx;
    logic                 memGo;
    logic [ENT_IDX_W-1:0] memIdx;
    logic                 memWrite;
  } lsu_strobe_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int NUM_LD = 3,
  parameter int NUM_ST = 2,
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            issueValid,
  input  logic                            issueIsStore,
  input  logic                            issueAfterBranch,
  input  logic                            branchResolved,
  input  logic [NUM_LD+NUM_ST-1:0]        baseRdy,
  input  logic [NUM_LD+NUM_ST-1:0]        dataRdy,
  input  logic [NUM_LD+NUM_ST-1:0][DATA_W-1:0] entAddr,
  output lsu_strobe_t                     strb,
  output logic                            ldFull,
  output logic                            stFull
);
  localparam int NE    = NUM_LD + NUM_ST;
  localparam int IDX_W = ENT_IDX_W;

  logic [NE-1:0]         valid, addrDone, memDone, gated;
  logic [NE-1:0][NE-1:0] olderM;   // olderM[i][j]: entry j issued before entry i
  logic                  bcastPend;
  logic [IDX_W-1:0]      bcastIdx;

  logic                  allocFound, allocGo;
  logic [IDX_W-1:0]      allocIdx;
  logic [NE-1:0]         agenReq, agenGnt, memReq, memGnt, memBlock, freeVec, allocVec;
  logic [IDX_W-1:0]      agenIdx, memIdx;
  logic                  memGo, memWrite;

  // free entry of the requested kind, lowest index first
  always_comb begin
    allocFound = 1'b0;
    allocIdx   = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (!valid[i] && ((i >= NUM_LD) == issueIsStore)) begin
        allocFound = 1'b1;
        allocIdx   = IDX_W'(i);
      end
    end
    allocGo = issueValid && allocFound;
    for (int i = 0; i < NE; i++) allocVec[i] = allocGo && (allocIdx == IDX_W'(i));
  end

  assign ldFull = &valid[NUM_LD-1:0];
  assign stFull = &valid[NE-1:NUM_LD];

  // requests for the shared adder and the memory port
  always_comb begin
    for (int i = 0; i < NE; i++) begin
      agenReq[i]  = valid[i] && !addrDone[i] && baseRdy[i] && !gated[i];
      memBlock[i] = 1'b0;
      for (int j = NUM_LD; j < NE; j++) begin
        if (j != i && olderM[i][j] && valid[j]) begin
          if (i >= NUM_LD) memBlock[i] = 1'b1;                       // stores keep issue order
          else if (!addrDone[j] || entAddr[j] == entAddr[i]) memBlock[i] = 1'b1;
        end
      end
      memReq[i] = valid[i] && addrDone[i] && !memDone[i] && dataRdy[i] && !memBlock[i];
    end
  end

  // oldest-first grant
  always_comb begin
    for (int i = 0; i < NE; i++) begin
      agenGnt[i] = agenReq[i];
      memGnt[i]  = memReq[i];
      for (int j = 0; j < NE; j++) begin
        if (agenReq[j] && olderM[i][j]) agenGnt[i] = 1'b0;
        if (memReq[j] && olderM[i][j])  memGnt[i]  = 1'b0;
      end
    end
    agenIdx = '0;
    memIdx  = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (agenGnt[i]) agenIdx = IDX_W'(i);
      if (memGnt[i])  memIdx  = IDX_W'(i);
    end
    memGo    = |memGnt;
    memWrite = memGo && (memIdx >= IDX_W'(NUM_LD));
    for (int i = 0; i < NE; i++)
      freeVec[i] = (bcastPend && bcastIdx == IDX_W'(i)) ||
                   (memWrite && memIdx == IDX_W'(i));
  end

  always_comb begin
    strb.alloc    = allocGo;
    strb.allocIdx = allocIdx;
    strb.agen     = |agenGnt;
    strb.agenIdx  = agenIdx;
    strb.memGo    = memGo;
    strb.memIdx   = memIdx;
    strb.memWrite = memWrite;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid     <= '0;
      addrDone  <= '0;
      memDone   <= '0;
      gated     <= '0;
      olderM    <= '0;
      bcastPend <= 1'b0;
      bcastIdx  <= '0;
    end else begin
      for (int i = 0; i < NE; i++) begin
        valid[i] <= (valid[i] && !freeVec[i]) || allocVec[i];
        if (allocVec[i]) begin
          addrDone[i] <= 1'b0;
          memDone[i]  <= 1'b0;
          gated[i]    <= issueAfterBranch && !branchResolved;
        end else begin
          addrDone[i] <= addrDone[i] || agenGnt[i];
          memDone[i]  <= memDone[i] || (memGnt[i] && i < NUM_LD);
          gated[i]    <= gated[i] && !branchResolved;
        end
        for (int j = 0; j < NE; j++)
          olderM[i][j] <= allocVec[i] ? (valid[j] && !freeVec[j])
                                      : (olderM[i][j] && !freeVec[j]);
      end
      bcastPend <= memGo && !memWrite;
      bcastIdx  <= memIdx;
    end
  end

  // R4: one address per cycle
  p_one_agen_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(agenGnt));
  // R9: one memory access per cycle
  p_one_mem_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(memGnt));

  for (genvar g = 0; g < NE; g++) begin : g_ent_chk
    // R10: a gated entry gains no address in the next cycle
    p_gate_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[g] && gated[g] && !addrDone[g]) |=> !addrDone[g]);
    // R11: a store entry is released right after its write
    p_store_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (memWrite && memIdx == IDX_W'(g)) |=> !valid[g]);
  end
endmodule

// File: rtl/lsu_dp.sv
module lsu_dp
  import lsu_pkg::*;
#(
  parameter int NUM_LD = 3,
  parameter int NUM_ST = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  lsu_strobe_t                     strb,
  input  logic                            issueIsStore,
  input  logic                            issueBaseRdy,
  input  logic [TAG_W-1:0]                issueBaseTag,
  input  logic [DATA_W-1:0]               issueBaseVal,
  input  logic [OFF_W-1:0]                issueOffset,
  input  logic                            issueDataRdy,
  input  logic [TAG_W-1:0]                issueDataTag,
  input  logic [DATA_W-1:0]               issueDataVal,
  input  logic [TAG_W-1:0]                issueDestTag,
  input  logic                            cdbValid,
  input  logic [TAG_W-1:0]                cdbTag,
  input  logic [DATA_W-1:0]               cdbData,
  input  logic [DATA_W-1:0]               memRdata,
  output logic [NUM_LD+NUM_ST-1:0]        baseRdy,
  output logic [NUM_LD+NUM_ST-1:0]        dataRdy,
  output logic [NUM_LD+NUM_ST-1:0][DATA_W-1:0] entAddr,
  output logic                            memEn,
  output logic                            memWe,
  output logic [DATA_W-1:0]               memAddr,
  output logic [DATA_W-1:0]               memWdata,
  output logic                            ldResValid,
  output logic [TAG_W-1:0]                ldResTag,
  output logic [DATA_W-1:0]               ldResData
);
  localparam int NE    = NUM_LD + NUM_ST;
  localparam int IDX_W = ENT_IDX_W;

  logic [NE-1:0][DATA_W-1:0] baseVal, dataVal;
  logic [NE-1:0][TAG_W-1:0]  baseTag, dataTag, destTag;
  logic [NE-1:0][OFF_W-1:0]  offset;
  logic [DATA_W-1:0]         agenSum;

  function automatic logic busHit(input logic v, input logic [TAG_W-1:0] t,
                                  input logic [TAG_W-1:0] want);
    return v && (t == want);
  endfunction

  // the single shared address adder
  assign agenSum = baseVal[strb.agenIdx] + DATA_W'($signed(offset[strb.agenIdx]));

  assign memEn    = strb.memGo;
  assign memWe    = strb.memGo && strb.memWrite;
  assign memAddr  = entAddr[strb.memIdx];
  assign memWdata = dataVal[strb.memIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseRdy    <= '0;
      dataRdy    <= '0;
      baseVal    <= '0;
      dataVal    <= '0;
      baseTag    <= '0;
      dataTag    <= '0;
      destTag    <= '0;
      offset     <= '0;
      entAddr    <= '0;
      ldResValid <= 1'b0;
      ldResTag   <= '0;
      ldResData  <= '0;
    end else begin
      for (int i = 0; i < NE; i++) begin
        if (strb.alloc && strb.allocIdx == IDX_W'(i)) begin
          baseTag[i] <= issueBaseTag;
          dataTag[i] <= issueDataTag;
          destTag[i] <= issueDestTag;
          offset[i]  <= issueOffset;
          if (issueBaseRdy) begin
            baseRdy[i] <= 1'b1; baseVal[i] <= issueBaseVal;
          end else if (busHit(cdbValid, cdbTag, issueBaseTag)) begin
            baseRdy[i] <= 1'b1; baseVal[i] <= cdbData;
          end else if (busHit(ldResValid, ldResTag, issueBaseTag)) begin
            baseRdy[i] <= 1'b1; baseVal[i] <= ldResData;
          end else begin
            baseRdy[i] <= 1'b0;
          end
          if (!issueIsStore || issueDataRdy) begin
            dataRdy[i] <= 1'b1; dataVal[i] <= issueDataVal;
          end else if (busHit(cdbValid, cdbTag, issueDataTag)) begin
            dataRdy[i] <= 1'b1; dataVal[i] <= cdbData;
          end else if (busHit(ldResValid, ldResTag, issueDataTag)) begin
            dataRdy[i] <= 1'b1; dataVal[i] <= ldResData;
          end else begin
            dataRdy[i] <= 1'b0;
          end
        end else begin
          if (!baseRdy[i] && busHit(cdbValid, cdbTag, baseTag[i])) begin
            baseRdy[i] <= 1'b1; baseVal[i] <= cdbData;
          end else if (!baseRdy[i] && busHit(ldResValid, ldResTag, baseTag[i])) begin
            baseRdy[i] <= 1'b1; baseVal[i] <= ldResData;
          end
          if (!dataRdy[i] && busHit(cdbValid, cdbTag, dataTag[i])) begin
            dataRdy[i] <= 1'b1; dataVal[i] <= cdbData;
          end else if (!dataRdy[i] && busHit(ldResValid, ldResTag, dataTag[i])) begin
            dataRdy[i] <= 1'b1; dataVal[i] <= ldResData;
          end
          if (strb.agen && strb.agenIdx == IDX_W'(i)) entAddr[i] <= agenSum;
        end
      end
      ldResValid <= strb.memGo && !strb.memWrite;
      ldResTag   <= destTag[strb.memIdx];
      ldResData  <= memRdata;
    end
  end

  // R3: a result is only presented one cycle after a memory read
  p_res_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ldResValid |-> $past(memEn && !memWe));
  // R7: a write is never followed by a result
  p_store_no_cdb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (memEn && memWe) |=> !ldResValid);
  // R9: write only with the port enabled
  p_we_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> memEn);
endmodule

// File: rtl/lsu_mem_pipe.sv
module lsu_mem_pipe
  import lsu_pkg::*;
#(
  parameter int NUM_LD = 3,
  parameter int NUM_ST = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic              issueIsStore,
  input  logic              issueAfterBranch,
  input  logic              issueBaseRdy,
  input  logic [TAG_W-1:0]  issueBaseTag,
  input  logic [DATA_W-1:0] issueBaseVal,
  input  logic [OFF_W-1:0]  issueOffset,
  input  logic              issueDataRdy,
  input  logic [TAG_W-1:0]  issueDataTag,
  input  logic [DATA_W-1:0] issueDataVal,
  input  logic [TAG_W-1:0]  issueDestTag,
  input  logic              branchResolved,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  output logic              ldFull,
  output logic              stFull,
  output logic              memEn,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              ldResValid,
  output logic [TAG_W-1:0]  ldResTag,
  output logic [DATA_W-1:0] ldResData
);
  localparam int NE = NUM_LD + NUM_ST;

  lsu_strobe_t               strb;
  logic [NE-1:0]             baseRdy, dataRdy;
  logic [NE-1:0][DATA_W-1:0] entAddr;

  lsu_ctrl #(.NUM_LD(NUM_LD), .NUM_ST(NUM_ST), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .issueValid(issueValid), .issueIsStore(issueIsStore),
    .issueAfterBranch(issueAfterBranch), .branchResolved(branchResolved),
    .baseRdy(baseRdy), .dataRdy(dataRdy), .entAddr(entAddr),
    .strb(strb), .ldFull(ldFull), .stFull(stFull)
  );

  lsu_dp #(.NUM_LD(NUM_LD), .NUM_ST(NUM_ST), .TAG_W(TAG_W), .DATA_W(DATA_W),
           .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .issueIsStore(issueIsStore), .issueBaseRdy(issueBaseRdy),
    .issueBaseTag(issueBaseTag), .issueBaseVal(issueBaseVal),
    .issueOffset(issueOffset), .issueDataRdy(issueDataRdy),
    .issueDataTag(issueDataTag), .issueDataVal(issueDataVal),
    .issueDestTag(issueDestTag),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .memRdata(memRdata),
    .baseRdy(baseRdy), .dataRdy(dataRdy), .entAddr(entAddr),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .ldResValid(ldResValid), .ldResTag(ldResTag), .ldResData(ldResData)
  );
endmodule

// File: tb/sim_lsu_mem_pipe.sv
module sim_lsu_mem_pipe;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issueValid = 0, issueIsStore = 0, issueAfterBranch = 0, issueBaseRdy = 0;
  logic [3:0]  issueBaseTag = 0, issueDataTag = 0, issueDestTag = 0;
  logic [15:0] issueBaseVal = 0, issueDataVal = 0;
  logic [5:0]  issueOffset = 0;
  logic issueDataRdy = 0, branchResolved = 0, cdbValid = 0;
  logic [3:0]  cdbTag = 0;
  logic [15:0] cdbData = 0;
  logic ldFull, stFull, memEn, memWe, ldResValid;
  logic [15:0] memAddr, memWdata, memRdata, ldResData;
  logic [3:0]  ldResTag;
  logic [15:0] mem [256];
  int checks = 0, errors = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  assign memRdata = mem[memAddr[7:0]];
  always @(posedge clk) if (memEn && memWe) mem[memAddr[7:0]] <= memWdata;

  lsu_mem_pipe u0 (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueIsStore(issueIsStore),
    .issueAfterBranch(issueAfterBranch), .issueBaseRdy(issueBaseRdy),
    .issueBaseTag(issueBaseTag), .issueBaseVal(issueBaseVal), .issueOffset(issueOffset),
    .issueDataRdy(issueDataRdy), .issueDataTag(issueDataTag), .issueDataVal(issueDataVal),
    .issueDestTag(issueDestTag), .branchResolved(branchResolved),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .ldFull(ldFull), .stFull(stFull), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .ldResValid(ldResValid), .ldResTag(ldResTag), .ldResData(ldResData)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic doIssue(input bit st, input bit ab, input bit brdy, input logic [3:0] btag,
                         input logic [15:0] bval, input logic [5:0] off, input bit drdy,
                         input logic [3:0] dtag, input logic [15:0] dval,
                         input logic [3:0] dest);
    issueValid = 1; issueIsStore = st; issueAfterBranch = ab; issueBaseRdy = brdy;
    issueBaseTag = btag; issueBaseVal = bval; issueOffset = off; issueDataRdy = drdy;
    issueDataTag = dtag; issueDataVal = dval; issueDestTag = dest;
    tick();
    issueValid = 0;
  endtask

  task automatic cdbPulse(input logic [3:0] tag, input logic [15:0] data);
    cdbValid = 1; cdbTag = tag; cdbData = data;
    tick();
    cdbValid = 0;
  endtask

  task automatic branchPulse();
    branchResolved = 1;
    tick();
    branchResolved = 0;
  endtask

  task automatic chkRead(input string req, input logic [15:0] addr);
    check({req, " read en"}, memEn, 1);
    check({req, " read we"}, memWe, 0);
    check({req, " read addr"}, memAddr, addr);
  endtask

  task automatic chkWrite(input string req, input logic [15:0] addr, input logic [15:0] data);
    check({req, " write en"}, memEn, 1);
    check({req, " write we"}, memWe, 1);
    check({req, " write addr"}, memAddr, addr);
    check({req, " write data"}, memWdata, data);
  endtask

  task automatic chkRes(input string req, input logic [3:0] tag, input logic [15:0] data);
    check({req, " result valid"}, ldResValid, 1);
    check({req, " result tag"}, ldResTag, tag);
    check({req, " result data"}, ldResData, data);
  endtask

  task automatic t_reset();
    check("R1 ldResValid", ldResValid, 0);
    check("R1 memEn", memEn, 0);
    check("R1 memWe", memWe, 0);
    check("R1 ldFull", ldFull, 0);
    check("R1 stFull", stFull, 0);
  endtask

  task automatic t_basic_load();
    doIssue(0, 0, 1, 0, 16'd100, 6'd0, 0, 0, 0, 4'd1);
    check("R3 no early read", memEn, 0);
    tick(); chkRead("R3", 16'd100);
    tick(); chkRes("R3", 4'd1, 16'd301);
    tick(); check("R3 one-cycle result", ldResValid, 0);
  endtask

  task automatic t_neg_offset();
    doIssue(0, 0, 1, 0, 16'd110, 6'h3E, 0, 0, 0, 4'd2);
    tick(); chkRead("R2 negative offset", 16'd108);
    tick(); chkRes("R2", 4'd2, 16'd325);
    tick();
  endtask

  task automatic t_capture();
    doIssue(0, 0, 0, 4'd3, 0, 6'd0, 0, 0, 0, 4'd4);
    doIssue(0, 0, 0, 4'd4, 0, 6'd0, 0, 0, 0, 4'd5);
    check("R5 waits for base", ldResValid, 0);
    cdbPulse(4'd3, 16'd20);
    check("R5 adder cycle", memEn, 0);
    tick(); chkRead("R5 external bus", 16'd20);
    tick(); chkRes("R5", 4'd4, 16'd61);
    tick(); check("R5 own bus adder cycle", memEn, 0);
    tick(); chkRead("R5 own bus", 16'd61);
    tick(); chkRes("R5 own bus", 4'd5, 16'd184);
    tick();
  endtask

  task automatic t_store_wait_data();
    doIssue(1, 0, 1, 0, 16'd40, 6'd4, 0, 4'd7, 0, 0);
    tick(); check("R6 no write without data", memEn, 0);
    tick(); check("R6 no write without data", memEn, 0);
    check("R7 store quiet", ldResValid, 0);
    cdbPulse(4'd7, 16'h1234);
    chkWrite("R6", 16'd44, 16'h1234);
    check("R7 store quiet", ldResValid, 0);
    tick(); check("R7 no result after write", ldResValid, 0);
    check("R11 store released", stFull, 0);
  endtask

  task automatic t_agen_order();
    doIssue(1, 0, 0, 4'd8, 0, 6'd4, 1, 0, 16'hAAAA, 0);
    doIssue(0, 0, 0, 4'd8, 0, 6'd0, 0, 0, 0, 4'd6);
    cdbPulse(4'd8, 16'd70);
    check("R4 adder cycle", memEn, 0);
    tick(); chkWrite("R4 older store first", 16'd74, 16'hAAAA);
    tick(); chkRead("R4 load second", 16'd70);
    tick(); chkRes("R4", 4'd6, 16'd211);
    tick();
  endtask

  task automatic t_raw_hold();
    doIssue(1, 0, 1, 0, 16'd90, 6'd0, 0, 4'd9, 0, 0);
    doIssue(0, 0, 1, 0, 16'd90, 6'd0, 0, 0, 0, 4'd7);
    tick(); tick();
    check("R8 load held on match", memEn, 0);
    check("R8 no result", ldResValid, 0);
    cdbPulse(4'd9, 16'h0BEE);
    chkWrite("R8 store first", 16'd90, 16'h0BEE);
    tick(); chkRead("R8 load after store", 16'd90);
    tick(); chkRes("R8 sees stored value", 4'd7, 16'h0BEE);
    tick();
  endtask

  task automatic t_unknown_addr();
    doIssue(1, 0, 0, 4'd10, 0, 6'd0, 0, 4'd11, 0, 0);
    doIssue(0, 0, 1, 0, 16'd50, 6'd0, 0, 0, 0, 4'd8);
    tick(); tick();
    check("R8 held on unknown address", memEn, 0);
    cdbPulse(4'd10, 16'd60);
    check("R8 store forming address", memEn, 0);
    tick(); chkRead("R8 differing address", 16'd50);
    tick(); chkRes("R8", 4'd8, 16'd151);
    cdbPulse(4'd11, 16'd5);
    chkWrite("R6 address before data", 16'd60, 16'd5);
    tick();
  endtask

  task automatic t_branch();
    doIssue(0, 1, 1, 0, 16'd30, 6'd0, 0, 0, 0, 4'd9);
    tick(); check("R10 gated", memEn, 0);
    tick(); tick(); check("R10 gated", memEn, 0);
    branchPulse();
    check("R10 adder cycle after resolve", memEn, 0);
    tick(); chkRead("R10", 16'd30);
    tick(); chkRes("R10", 4'd9, 16'd91);
    tick();
  endtask

  task automatic t_port_order();
    doIssue(0, 0, 0, 4'd12, 0, 6'd0, 0, 0, 0, 4'd10);
    doIssue(1, 0, 1, 0, 16'd80, 6'd0, 0, 4'd13, 0, 0);
    tick(); tick();
    cdbPulse(4'd12, 16'd20);
    cdbPulse(4'd13, 16'h0777);
    chkRead("R9 older load first", 16'd20);
    tick(); chkWrite("R9 younger store next", 16'd80, 16'h0777);
    chkRes("R9", 4'd10, 16'd61);
    tick();
  endtask

  task automatic t_load_full();
    doIssue(0, 1, 1, 0, 16'd1, 6'd0, 0, 0, 0, 4'd11);
    doIssue(0, 1, 1, 0, 16'd2, 6'd0, 0, 0, 0, 4'd12);
    doIssue(0, 1, 1, 0, 16'd3, 6'd0, 0, 0, 0, 4'd13);
    check("R11 ldFull", ldFull, 1);
    check("R11 stFull clear", stFull, 0);
    branchPulse();
    tick(); chkRead("R4 oldest load", 16'd1);
    tick(); check("R11 held through result", ldFull, 1);
    chkRes("R11 first", 4'd11, 16'd4);
    tick(); check("R11 released after result", ldFull, 0);
    chkRes("R11 second", 4'd12, 16'd7);
    tick(); chkRes("R11 third", 4'd13, 16'd10);
    tick();
  endtask

  task automatic t_store_full();
    doIssue(1, 0, 1, 0, 16'd120, 6'd0, 0, 4'd14, 0, 0);
    doIssue(1, 0, 1, 0, 16'd121, 6'd0, 0, 4'd14, 0, 0);
    check("R11 stFull", stFull, 1);
    cdbPulse(4'd14, 16'h0ABC);
    chkWrite("R6 older store", 16'd120, 16'h0ABC);
    check("R11 stFull held", stFull, 1);
    tick(); chkWrite("R6 younger store", 16'd121, 16'h0ABC);
    check("R11 stFull drops", stFull, 0);
    check("R7 stores quiet", ldResValid, 0);
    tick(); check("R9 idle", memEn, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_basic_load();
    t_neg_offset();
    t_capture();
    t_store_wait_data();
    t_agen_order();
    t_raw_hold();
    t_unknown_addr();
    t_branch();
    t_port_order();
    t_load_full();
    t_store_full();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule